// File: doc/BRIEF.md
# Double-Buffered BCD Clock Calendar

This block keeps calendar time in packed BCD. A clock-enable pulse at the oscillator rate (32.768 kHz by default) drives a prescaler. The prescaler produces one strobe per second, and that strobe advances a cascade of counters for seconds, minutes, hours (00–23), day of week, date, month, year and century. The cascade corrects month lengths and leap years by itself.

The host never reads the running counters directly. It reads and writes a second, host-visible copy of the time through a byte-wide register port. The port has an active-low select, an active-low write strobe and a 4-bit address. Writes take effect on the clock edge. Read data is combinational from the address.

While neither hold bit is set, the host copy follows the counters on every clock. A read-hold bit freezes the host copy so a multi-byte read is consistent, and the counters keep running meanwhile. A write-hold bit turns the host copy into a staging area. Clearing that bit loads every staged field into the counters and restarts the second from zero. A stop bit in the seconds register halts the prescaler and the counters, so timekeeping stops.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds 0x80 (stop bit set, count 00), minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00, and control 0x20 (both hold bits clear, century 20).
- R2: With timekeeping running, the seconds count advances by one after every PRESCALE_DIV clock-enable pulses. Clock cycles without an enable pulse do not count.
- R3: Bit 7 of the seconds register (address 9h) is the stop bit: 1 halts the prescaler and all counters, 0 lets them run. A write to it takes effect at once, whatever the hold bits are.
- R4: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into date and day of week.
- R5: Day of week (address Ch) counts 01 to 07 and wraps from 07 to 01 when the day ends.
- R6: The date (Dh) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The month (Eh) then advances, and month 12 wraps to 01 and carries into the year (Fh).
- R7: February ends at 29 when the BCD year is divisible by four, 00 included, and at 28 otherwise.
- R8: When the year wraps from 99 to 00, the century advances. The century is held in control bits 5:0 as BCD and wraps from 39 to 00.
- R9: Writing 1 to control bit 6 (read hold) freezes all host-visible time fields at the count current at that write, while the counters keep running. After the bit is written 0, the host view shows the live count within two clock cycles.
- R10: Writing 1 to control bit 7 (write hold) stops refreshing of the host view, and time writes then land in it. A control write with bit 7 at 0 while the bit is set loads every staged field, including the century bits of that write, into the counters and restarts the prescaler at zero.
- R11: Writes to time fields while both hold bits are clear do not change the counters. Apart from the stop bit, the next refresh overwrites them.
- R12: Addresses 0h to 7h read as 0x00 and ignore writes, and read data is 0x00 while the select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| cs_n | input | 1 | Active-low register select |
| wr_n | input | 1 | Active-low write strobe, sampled with cs_n on the clock edge |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |

## Verification
A wrong carry or month-length decision shows at the ports one clock after the second strobe that crosses the boundary. The host view copies the counters on the next edge, so a read two cycles after the last enable pulse exposes it. A hold bit that fails to freeze or fails to release shows as a seconds value that moved when it should not have, or stayed when it should have moved, within two cycles of the control write. A commit that loses a field, or keeps a stale prescaler phase, shows as a wrong staged value read back, or as a second that ends early, inside one PRESCALE_DIV window.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } cal_time_t;

   localparam logic [3:0] A_CTRL = 4'h8;
   localparam logic [3:0] A_SEC  = 4'h9;
   localparam logic [3:0] A_MIN  = 4'hA;
   localparam logic [3:0] A_HR   = 4'hB;
   localparam logic [3:0] A_DOW  = 4'hC;
   localparam logic [3:0] A_DATE = 4'hD;
   localparam logic [3:0] A_MON  = 4'hE;
   localparam logic [3:0] A_YR   = 4'hF;

   localparam int unsigned CHAIN_LEN = 7;

   // lower bound of each chained field: sec, min, hr, date, mon, yr, cent
   function automatic logic [7:0] chain_lo(input int unsigned idx);
      case (idx)
         3, 4:    chain_lo = 8'h01;
         default: chain_lo = 8'h00;
      endcase
   endfunction

   // upper bound of each chained field; the date bound is computed elsewhere
   function automatic logic [7:0] chain_hi(input int unsigned idx);
      case (idx)
         0, 1:    chain_hi = 8'h59;
         2:       chain_hi = 8'h23;
         4:       chain_hi = 8'h12;
         5:       chain_hi = 8'h99;
         6:       chain_hi = 8'h39;
         default: chain_hi = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic pulse
);
   localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   assign pulse = run && !clear && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (run) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cal_bcd_step.sv
`timescale 1ns/1ps
module cal_bcd_step (
   input  logic [7:0] val,
   input  logic [7:0] lo,
   input  logic [7:0] hi,
   input  logic       inc,
   output logic [7:0] nxt
);
   always_comb begin
      if (!inc) begin
         nxt = val;
      end else if (val >= hi) begin
         nxt = lo;
      end else if (val[3:0] >= 4'd9) begin
         nxt = {val[7:4] + 4'd1, 4'h0};
      end else begin
         nxt = val + 8'd1;
      end
   end
endmodule

// File: rtl/cal_day_limit.sv
`timescale 1ns/1ps
module cal_day_limit (
   input  logic [7:0] mon,
   input  logic       yr_tens_lsb,
   input  logic [1:0] yr_ones_lo,
   output logic [7:0] last_date
);
   logic leap;

   // A BCD year is a multiple of four when an even tens digit meets ones
   // 0/4/8, or an odd tens digit meets ones 2/6.
   assign leap = yr_tens_lsb ? (yr_ones_lo == 2'b10) : (yr_ones_lo == 2'b00);

   always_comb begin
      case (mon)
         8'h02:                      last_date = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
         default:                    last_date = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV      = 32768,
   parameter bit          OSC_STOP_AT_RESET = 1'b1,
   parameter logic [7:0]  RESET_CENTURY     = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       cs_n,
   input  logic       wr_n,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);
   localparam cal_time_t RESET_TIME = '{
      cent: RESET_CENTURY, yr: 8'h00, mon: 8'h01, date: 8'h01,
      dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

   generate
      if (PRESCALE_DIV < 2) begin : g_bad_div
         $error("PRESCALE_DIV must be at least 2");
      end
      if (RESET_CENTURY > 8'h39 || RESET_CENTURY[3:0] > 4'd9) begin : g_bad_cent
         $error("RESET_CENTURY must be BCD 00 to 39");
      end
   endgenerate

   cal_time_t cnt_q, cnt_next, view_q, view_wr;
   logic      osc_stop_q, wbit_q, rbit_q;
   logic      host_wr, ctrl_wr, commit, hold, sec_pulse;
   logic [7:0] last_date;

   assign host_wr = !cs_n && !wr_n;
   assign ctrl_wr = host_wr && (addr == A_CTRL);
   assign commit  = ctrl_wr && wbit_q && !wdata[7];
   assign hold    = wbit_q || rbit_q;

   // ---------------- prescaler ----------------
   cal_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (osc_tick && !osc_stop_q),
      .clear (commit),
      .pulse (sec_pulse)
   );

   // ---------------- month length ----------------
   cal_day_limit u_limit (
      .mon         (cnt_q.mon),
      .yr_tens_lsb (cnt_q.yr[4]),
      .yr_ones_lo  (cnt_q.yr[1:0]),
      .last_date   (last_date)
   );

   // ---------------- carry chain ----------------
   logic [7:0]           cur_v [CHAIN_LEN];
   logic [7:0]           hi_v  [CHAIN_LEN];
   logic [7:0]           nxt_v [CHAIN_LEN];
   logic [CHAIN_LEN-1:0] inc_v;
   logic [7:0]           dow_nxt;

   assign cur_v = '{cnt_q.sec, cnt_q.min, cnt_q.hr, cnt_q.date,
                    cnt_q.mon, cnt_q.yr, cnt_q.cent};
   assign inc_v[0] = sec_pulse;

   generate
      for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_chain
         if (i == 3) begin : g_date_hi
            assign hi_v[i] = last_date;
         end else begin : g_const_hi
            assign hi_v[i] = chain_hi(i);
         end
         cal_bcd_step u_step (
            .val (cur_v[i]),
            .lo  (chain_lo(i)),
            .hi  (hi_v[i]),
            .inc (inc_v[i]),
            .nxt (nxt_v[i])
         );
         if (i < CHAIN_LEN - 1) begin : g_carry
            assign inc_v[i+1] = inc_v[i] && (cur_v[i] >= hi_v[i]);
         end
      end
   endgenerate

   // day of week advances with the date
   cal_bcd_step u_dow (
      .val (cnt_q.dow),
      .lo  (8'h01),
      .hi  (8'h07),
      .inc (inc_v[3]),
      .nxt (dow_nxt)
   );

   always_comb begin
      cnt_next      = cnt_q;
      cnt_next.sec  = nxt_v[0];
      cnt_next.min  = nxt_v[1];
      cnt_next.hr   = nxt_v[2];
      cnt_next.date = nxt_v[3];
      cnt_next.mon  = nxt_v[4];
      cnt_next.yr   = nxt_v[5];
      cnt_next.cent = nxt_v[6];
      cnt_next.dow  = dow_nxt;
   end

   // ---------------- host view with write merge ----------------
   always_comb begin
      view_wr = view_q;
      if (host_wr) begin
         case (addr)
            A_CTRL: view_wr.cent = wdata & 8'h3F;
            A_SEC:  view_wr.sec  = wdata & 8'h7F;
            A_MIN:  view_wr.min  = wdata & 8'h7F;
            A_HR:   view_wr.hr   = wdata & 8'h3F;
            A_DOW:  view_wr.dow  = wdata & 8'h07;
            A_DATE: view_wr.date = wdata & 8'h3F;
            A_MON:  view_wr.mon  = wdata & 8'h1F;
            A_YR:   view_wr.yr   = wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= RESET_TIME;
         view_q     <= RESET_TIME;
         osc_stop_q <= OSC_STOP_AT_RESET;
         wbit_q     <= 1'b0;
         rbit_q     <= 1'b0;
      end else begin
         cnt_q  <= commit ? view_wr : cnt_next;
         view_q <= hold ? view_wr : cnt_q;
         if (host_wr && addr == A_SEC) osc_stop_q <= wdata[7];
         if (ctrl_wr) begin
            wbit_q <= wdata[7];
            rbit_q <= wdata[6];
         end
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      rdata = 8'h00;
      if (!cs_n) begin
         case (addr)
            A_CTRL: rdata = {wbit_q, rbit_q, view_q.cent[5:0]};
            A_SEC:  rdata = {osc_stop_q, view_q.sec[6:0]};
            A_MIN:  rdata = view_q.min;
            A_HR:   rdata = view_q.hr;
            A_DOW:  rdata = view_q.dow;
            A_DATE: rdata = view_q.date;
            A_MON:  rdata = view_q.mon;
            A_YR:   rdata = view_q.yr;
            default: rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker
   import cal_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      host_wr,
   input logic      hold,
   input logic      commit,
   input logic      sec_pulse,
   input logic      osc_stop,
   input cal_time_t cnt,
   input cal_time_t view,
   input cal_time_t view_wr
);
   assert_pulse_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop |-> !sec_pulse);

   assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && !commit) |=> $stable(cnt));

   assert_second_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !commit) |=> (cnt.sec != $past(cnt.sec)));

   assert_view_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> (view == $past(cnt)));

   assert_view_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !host_wr) |=> $stable(view));

   assert_commit_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (cnt == $past(view_wr)));
endmodule

bind bcd_calendar cal_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .hold      (hold),
   .commit    (commit),
   .sec_pulse (sec_pulse),
   .osc_stop  (osc_stop_q),
   .cnt       (cnt_q),
   .view      (view_q),
   .view_wr   (view_wr)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       cs_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bcd_calendar #(.PRESCALE_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cs_n(cs_n),
      .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata));

   // {start, expected}; each half is cent yr mon date dow hr min sec
   localparam logic [127:0] VEC [12] = '{
      {64'h2023_0228_0323_5959, 64'h2023_0301_0400_0000},
      {64'h2024_0228_0323_5959, 64'h2024_0229_0400_0000},
      {64'h2024_0229_0423_5959, 64'h2024_0301_0500_0000},
      {64'h2024_0430_0723_5959, 64'h2024_0501_0100_0000},
      {64'h2024_0530_0223_5959, 64'h2024_0531_0300_0000},
      {64'h2024_1231_0223_5959, 64'h2025_0101_0300_0000},
      {64'h2099_1231_0423_5959, 64'h2100_0101_0500_0000},
      {64'h3999_1231_0423_5959, 64'h0000_0101_0500_0000},
      {64'h2025_0615_0310_5959, 64'h2025_0615_0311_0000},
      {64'h2025_0615_0310_2059, 64'h2025_0615_0310_2100},
      {64'h2000_0228_0123_5959, 64'h2000_0229_0200_0000},
      {64'h2026_0228_0623_5959, 64'h2026_0301_0700_0000}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b1; addr = a;
      #2 d = rdata;
      cs_n = 1'b1;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic set_time(input logic [63:0] t);
      bus_wr(4'h8, {2'b10, t[61:56]});
      bus_wr(4'hF, t[55:48]);
      bus_wr(4'hE, t[47:40]);
      bus_wr(4'hD, t[39:32]);
      bus_wr(4'hC, t[31:24]);
      bus_wr(4'hB, t[23:16]);
      bus_wr(4'hA, t[15:8]);
      bus_wr(4'h9, {1'b0, t[6:0]});
      bus_wr(4'h8, {2'b00, t[61:56]});
      repeat (2) @(negedge clk);
   endtask

   task automatic read_all(output logic [63:0] t);
      logic [7:0] b;
      bus_rd(4'h8, b); t[63:56] = {2'b00, b[5:0]};
      bus_rd(4'hF, b); t[55:48] = b;
      bus_rd(4'hE, b); t[47:40] = b;
      bus_rd(4'hD, b); t[39:32] = b;
      bus_rd(4'hC, b); t[31:24] = b;
      bus_rd(4'hB, b); t[23:16] = b;
      bus_rd(4'hA, b); t[15:8]  = b;
      bus_rd(4'h9, b); t[7:0]   = {1'b0, b[6:0]};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog (R1) actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [63:0] t;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      bus_rd(4'h9, b); check("R1 seconds", b, 8'h80);
      bus_rd(4'hA, b); check("R1 minutes", b, 8'h00);
      bus_rd(4'hB, b); check("R1 hours", b, 8'h00);
      bus_rd(4'hC, b); check("R1 weekday", b, 8'h01);
      bus_rd(4'hD, b); check("R1 date", b, 8'h01);
      bus_rd(4'hE, b); check("R1 month", b, 8'h01);
      bus_rd(4'hF, b); check("R1 year", b, 8'h00);
      bus_rd(4'h8, b); check("R1 control", b, 8'h20);

      // R3: stopped after reset, enables are ignored
      ticks(3 * DIV);
      bus_rd(4'h9, b); check("R3 stopped count", b, 8'h80);

      // R12: low addresses and deselected reads
      bus_wr(4'h3, 8'hFF);
      bus_rd(4'h3, b); check("R12 low address", b, 8'h00);
      @(negedge clk); cs_n = 1'b1; addr = 4'h8; #2;
      check("R12 deselected", rdata, 8'h00);

      // R11: unheld time write is dropped
      bus_wr(4'hA, 8'h45);
      repeat (2) @(negedge clk);
      bus_rd(4'hA, b); check("R11 minutes unchanged", b, 8'h00);

      // R3 start, R2 rate
      bus_wr(4'h9, 8'h00);
      ticks(DIV);
      bus_rd(4'h9, b); check("R3 running", b, 8'h01);
      ticks(DIV - 1);
      repeat (10) @(negedge clk);
      bus_rd(4'h9, b); check("R2 partial second", b, 8'h01);
      ticks(1);
      bus_rd(4'h9, b); check("R2 full second", b, 8'h02);

      // R3 stop again
      bus_wr(4'h9, 8'h80);
      ticks(2 * DIV);
      bus_rd(4'h9, b); check("R3 stopped again", b, 8'h82);

      // R10: staging, commit, prescaler restart
      bus_wr(4'h8, 8'hA0);
      bus_wr(4'h9, 8'h30);
      ticks(DIV);
      bus_rd(4'h9, b); check("R10 staged view held", b, 8'h30);
      bus_wr(4'h8, 8'h20);
      repeat (2) @(negedge clk);
      bus_rd(4'h9, b); check("R10 committed", b, 8'h30);
      ticks(DIV - 1);
      bus_rd(4'h9, b); check("R10 prescaler restarted", b, 8'h30);
      ticks(1);
      bus_rd(4'h9, b); check("R10 first second", b, 8'h31);

      // R9: freeze and release
      bus_wr(4'h8, 8'h60);
      ticks(2 * DIV);
      bus_rd(4'h9, b); check("R9 frozen", b, 8'h31);
      bus_wr(4'h8, 8'h20);
      repeat (2) @(negedge clk);
      bus_rd(4'h9, b); check("R9 released", b, 8'h33);

      // calendar vectors: R4 R5 R6 R7 R8
      for (int v = 0; v < 12; v++) begin
         set_time(VEC[v][127:64]);
         ticks(DIV);
         read_all(t);
         check($sformatf("R4 R5 R6 R7 R8 vector %0d", v), t, VEC[v][63:0]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule